// File: doc/BRIEF.md
# Load/Store Ordering Unit with No-Alias Load Bypass

This block sits between the memory-operation scheduling stage and a single cache port. Loads and stores enter one at a time in program order. They wait in a small in-order holding queue and leave it strictly from the head. A store that leaves the queue has its address computed and moves into a store buffer. It stays there until the retirement logic names its tag as ready to retire. Buffered stores then write the cache one at a time, oldest first.

A load that reaches the head of the queue may go to the cache ahead of older buffered stores, but only when no buffered store holds exactly the same address. No data is forwarded from the store buffer. A load that hits a buffered address waits until that store has left the buffer through the cache port. The cache port serves one access per cycle and always completes in that cycle. When a retiring store and a load both want the port, the store wins. An operation presented to an empty queue can issue in the same cycle it arrives.

Top module: `mem_order_unit`

## Requirements
- R1: While reset is high and in the cycle after it falls, `cache_valid` is 0 and `disp_ready` is 1. A store accepted before a reset never reaches the cache afterwards.
- R2: At most one cache access occurs per cycle. When the oldest buffered store is ready to retire, it takes the port with `cache_we`=1, and a load that could otherwise issue waits one cycle.
- R3: A store can write the cache no earlier than the cycle after `ret_valid` names its tag. A `ret_valid` whose tag matches no buffered store has no effect.
- R4: Stores write the cache in the order they were dispatched. A store buffered behind a store that is not yet ready does not write the cache, even if it is ready itself.
- R5: A load whose full-width address equals the address of any valid buffered store does not access the cache until that store has written the cache. It issues in the cycle after that write at the earliest.
- R6: A load whose address matches no buffered store reaches the cache (`cache_valid`=1, `cache_we`=0, its tag) ahead of older buffered stores that are not ready. Addresses that differ only in the most significant bit count as different.
- R7: Operations leave the holding queue in program order. A load behind a stalled store waits, even if it has no alias.
- R8: An operation dispatched into an empty holding queue can issue in its dispatch cycle.
- R9: A store at the queue head stalls while the store buffer holds `SB_DEPTH` entries. The queue accepts up to `RS_DEPTH` waiting operations, then drives `disp_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | An operation is offered for dispatch |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_tag | input | TAG_W | Operation tag |
| disp_addr | input | ADDR_W | Computed memory address |
| disp_ready | output | 1 | Holding queue can accept an operation |
| ret_valid | input | 1 | A store is ready to retire |
| ret_tag | input | TAG_W | Tag of the retiring store |
| cache_valid | output | 1 | Cache access this cycle |
| cache_we | output | 1 | 1 = store write, 0 = load read |
| cache_tag | output | TAG_W | Tag of the accessing operation |
| cache_addr | output | ADDR_W | Address of the access |

## Verification
A wrong ready bit or head pointer in the store buffer shows up at the cache port in the very cycle the head should move. A store then appears too early, out of order or never, and a load granted in a store's slot shows `cache_we`=0 where 1 was due. A missed alias match shows up at once as a load tag on the port while a store to the same address is still pending. A queue count error shows up as `disp_ready` falling one entry too soon or too late, or as a load leaving ahead of a stalled store.

// File: rtl/mou_pkg.sv
package mou_pkg;
    parameter int ADDR_W = 16;
    parameter int TAG_W  = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic  is_store;
        tag_t  tag;
        addr_t addr;
    } mem_op_t;

    typedef struct packed {
        logic  valid;
        logic  ready;
        tag_t  tag;
        addr_t addr;
    } sb_entry_t;

    typedef struct packed {
        logic  valid;
        logic  we;
        tag_t  tag;
        addr_t addr;
    } cache_req_t;
endpackage

// File: rtl/mou_rs_queue.sv
module mou_rs_queue
    import mou_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  mem_op_t in_op,
    output logic    in_ready,
    output logic    head_valid,
    output mem_op_t head_op,
    input  logic    head_pop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    mem_op_t            slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;
    logic               empty, push, pop_slot;

    assign empty      = (count == '0);
    assign in_ready   = (count != FULL_CNT);
    // empty queue: incoming op is presented at the head in its dispatch cycle
    assign head_valid = !empty || in_valid;
    assign head_op    = empty ? in_op : slots[rd_ptr];
    assign push       = in_valid && in_ready && !(empty && head_pop);
    assign pop_slot   = head_pop && !empty;

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= in_op;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_slot) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(push) - CNT_W'(pop_slot);
        end
    end
endmodule

// File: rtl/mou_store_buffer.sv
module mou_store_buffer
    import mou_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  tag_t             push_tag,
    input  addr_t            push_addr,
    input  logic             ret_valid,
    input  tag_t             ret_tag,
    input  logic             pop,
    input  addr_t            query_addr,
    output logic             alias_hit,
    output logic             full,
    output logic             head_ready,
    output tag_t             head_tag,
    output addr_t            head_addr,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    sb_entry_t          ent [DEPTH];
    logic [DEPTH-1:0]   hit_vec;
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    sb_entry_t          head;

    // exact full-width compare against every valid entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = ent[g].valid && (ent[g].addr == query_addr);
    end

    assign alias_hit  = |hit_vec;
    assign head       = ent[rd_ptr];
    assign head_ready = head.valid && head.ready;
    assign head_tag   = head.tag;
    assign head_addr  = head.addr;
    assign full       = (count == FULL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= '0;
            end
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ret_valid && ent[i].valid && (ent[i].tag == ret_tag)) begin
                    ent[i].ready <= 1'b1;
                end
            end
            if (pop) begin
                ent[rd_ptr].valid <= 1'b0;
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push) begin
                ent[wr_ptr] <= '{valid: 1'b1, ready: 1'b0, tag: push_tag, addr: push_addr};
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/mou_port_arbiter.sv
module mou_port_arbiter
    import mou_pkg::*;
(
    input  logic       rs_head_valid,
    input  mem_op_t    rs_head,
    input  logic       sb_full,
    input  logic       ld_alias,
    input  logic       sb_head_ready,
    input  tag_t       sb_head_tag,
    input  addr_t      sb_head_addr,
    output logic       rs_pop,
    output logic       sb_push,
    output logic       sb_pop,
    output cache_req_t req
);
    logic st_issue, ld_issue;

    assign st_issue = rs_head_valid && rs_head.is_store && !sb_full;
    // retiring store owns the port; aliasing loads wait for the write
    assign ld_issue = rs_head_valid && !rs_head.is_store && !ld_alias && !sb_head_ready;

    assign sb_push = st_issue;
    assign sb_pop  = sb_head_ready;
    assign rs_pop  = st_issue || ld_issue;

    always_comb begin
        req = '0;
        if (sb_head_ready) begin
            req = '{valid: 1'b1, we: 1'b1, tag: sb_head_tag, addr: sb_head_addr};
        end else if (ld_issue) begin
            req = '{valid: 1'b1, we: 1'b0, tag: rs_head.tag, addr: rs_head.addr};
        end
    end
endmodule

// File: rtl/mem_order_unit.sv
module mem_order_unit
    import mou_pkg::*;
#(
    parameter int RS_DEPTH = 4,
    parameter int SB_DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       disp_valid,
    input  logic                       disp_is_store,
    input  logic [mou_pkg::TAG_W-1:0]  disp_tag,
    input  logic [mou_pkg::ADDR_W-1:0] disp_addr,
    output logic                       disp_ready,
    input  logic                       ret_valid,
    input  logic [mou_pkg::TAG_W-1:0]  ret_tag,
    output logic                       cache_valid,
    output logic                       cache_we,
    output logic [mou_pkg::TAG_W-1:0]  cache_tag,
    output logic [mou_pkg::ADDR_W-1:0] cache_addr
);
    localparam int SB_CNT_W = $clog2(SB_DEPTH + 1);

    mem_op_t             disp_op, rs_head;
    logic                rs_head_valid, rs_pop;
    logic                sb_push, sb_pop, sb_full, sb_head_ready, ld_alias;
    tag_t                sb_head_tag;
    addr_t               sb_head_addr;
    logic [SB_CNT_W-1:0] sb_count;
    cache_req_t          req;

    assign disp_op = '{is_store: disp_is_store, tag: disp_tag, addr: disp_addr};

    mou_rs_queue #(.DEPTH(RS_DEPTH)) u_rsq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (disp_valid),
        .in_op      (disp_op),
        .in_ready   (disp_ready),
        .head_valid (rs_head_valid),
        .head_op    (rs_head),
        .head_pop   (rs_pop)
    );

    mou_store_buffer #(.DEPTH(SB_DEPTH)) u_sb (
        .clk        (clk),
        .rst        (rst),
        .push       (sb_push),
        .push_tag   (rs_head.tag),
        .push_addr  (rs_head.addr),
        .ret_valid  (ret_valid),
        .ret_tag    (ret_tag),
        .pop        (sb_pop),
        .query_addr (rs_head.addr),
        .alias_hit  (ld_alias),
        .full       (sb_full),
        .head_ready (sb_head_ready),
        .head_tag   (sb_head_tag),
        .head_addr  (sb_head_addr),
        .count      (sb_count)
    );

    mou_port_arbiter u_arb (
        .rs_head_valid (rs_head_valid),
        .rs_head       (rs_head),
        .sb_full       (sb_full),
        .ld_alias      (ld_alias),
        .sb_head_ready (sb_head_ready),
        .sb_head_tag   (sb_head_tag),
        .sb_head_addr  (sb_head_addr),
        .rs_pop        (rs_pop),
        .sb_push       (sb_push),
        .sb_pop        (sb_pop),
        .req           (req)
    );

    assign cache_valid = req.valid;
    assign cache_we    = req.we;
    assign cache_tag   = req.tag;
    assign cache_addr  = req.addr;
endmodule

// File: rtl/mou_checker.sv
module mou_checker #(
    parameter int SB_DEPTH = 2,
    localparam int CNT_W = $clog2(SB_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cache_valid,
    input logic             cache_we,
    input logic             sb_head_ready,
    input logic             ld_alias,
    input logic             sb_full,
    input logic             sb_push,
    input logic             rs_pop,
    input logic             rs_head_valid,
    input logic [CNT_W-1:0] sb_count
);
    // R2
    store_first_chk: assert property (@(posedge clk) disable iff (rst)
        sb_head_ready |-> (cache_valid && cache_we));

    // R5
    no_alias_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cache_valid && !cache_we) |-> !ld_alias);

    // R9
    full_no_push_chk: assert property (@(posedge clk) disable iff (rst)
        sb_full |-> !sb_push);

    // R9
    sb_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sb_count <= CNT_W'(SB_DEPTH));

    // R7
    pop_needs_head_chk: assert property (@(posedge clk) disable iff (rst)
        rs_pop |-> rs_head_valid);

    // R4
    store_from_buffer_chk: assert property (@(posedge clk) disable iff (rst)
        (cache_valid && cache_we) |-> (sb_count != '0));
endmodule

bind mem_order_unit mou_checker #(.SB_DEPTH(SB_DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cache_valid   (cache_valid),
    .cache_we      (cache_we),
    .sb_head_ready (sb_head_ready),
    .ld_alias      (ld_alias),
    .sb_full       (sb_full),
    .sb_push       (sb_push),
    .rs_pop        (rs_pop),
    .rs_head_valid (rs_head_valid),
    .sb_count      (sb_count)
);

// File: tb/mem_order_unit_tb.sv
module mem_order_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        disp_valid, disp_is_store, ret_valid;
    logic [3:0]  disp_tag, ret_tag;
    logic [15:0] disp_addr;
    logic        disp_ready, cache_valid, cache_we;
    logic [3:0]  cache_tag;
    logic [15:0] cache_addr;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mem_order_unit #(.RS_DEPTH(4), .SB_DEPTH(2)) u_dut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_is_store(disp_is_store),
        .disp_tag(disp_tag), .disp_addr(disp_addr), .disp_ready(disp_ready),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .cache_valid(cache_valid), .cache_we(cache_we),
        .cache_tag(cache_tag), .cache_addr(cache_addr)
    );

    typedef struct packed {
        logic        dv;
        logic        st;
        logic [3:0]  tag;
        logic [15:0] addr;
        logic        rv;
        logic [3:0]  rtag;
        logic        ev;
        logic        ewe;
        logic [3:0]  etag;
        logic        erdy;
        logic [3:0]  req;
    } row_t;

    // one row per cycle: dispatch, retire, expected port state, requirement
    localparam row_t TBL [26] = '{
        '{1, 1,  1, 16'h0010, 0,  0, 0, 0,  0, 1, 8}, // R8 store enters buffer at once
        '{1, 0,  2, 16'h0010, 1,  1, 0, 0,  0, 1, 3}, // R3 ready this cycle, no write yet; R5 alias
        '{1, 0,  3, 16'h0020, 0,  0, 1, 1,  1, 1, 3}, // R3 store writes next cycle
        '{0, 0,  0, 16'h0000, 0,  0, 1, 0,  2, 1, 5}, // R5 aliasing load after write
        '{0, 0,  0, 16'h0000, 0,  0, 1, 0,  3, 1, 7}, // R7 program order
        '{1, 1,  4, 16'h0030, 0,  0, 0, 0,  0, 1, 8},
        '{1, 0,  5, 16'h0040, 0,  0, 1, 0,  5, 1, 6}, // R6 bypass
        '{1, 0,  6, 16'h0050, 1,  4, 1, 0,  6, 1, 6}, // R6 bypass
        '{1, 0,  7, 16'h0060, 0,  0, 1, 1,  4, 1, 2}, // R2 store wins port
        '{0, 0,  0, 16'h0000, 0,  0, 1, 0,  7, 1, 2}, // R2 load one cycle later
        '{1, 1,  8, 16'h0070, 0,  0, 0, 0,  0, 1, 9},
        '{1, 1,  9, 16'h0080, 0,  0, 0, 0,  0, 1, 9},
        '{1, 1, 10, 16'h0090, 0,  0, 0, 0,  0, 1, 9}, // R9 buffer full, store held
        '{1, 0, 11, 16'h00A0, 0,  0, 0, 0,  0, 1, 7}, // R7 load behind stalled store
        '{0, 0,  0, 16'h0000, 1,  8, 0, 0,  0, 1, 3},
        '{0, 0,  0, 16'h0000, 0,  0, 1, 1,  8, 1, 4}, // R4
        '{0, 0,  0, 16'h0000, 0,  0, 0, 0,  0, 1, 9}, // R9 held store moves in
        '{0, 0,  0, 16'h0000, 0,  0, 1, 0, 11, 1, 7}, // R7
        '{0, 0,  0, 16'h0000, 1,  9, 0, 0,  0, 1, 4},
        '{0, 0,  0, 16'h0000, 1, 10, 1, 1,  9, 1, 4}, // R4
        '{0, 0,  0, 16'h0000, 0,  0, 1, 1, 10, 1, 4}, // R4
        '{0, 0,  0, 16'h0000, 1, 15, 0, 0,  0, 1, 3}, // R3 unknown tag ignored
        '{1, 1, 12, 16'h8010, 0,  0, 0, 0,  0, 1, 8},
        '{1, 0, 13, 16'h0010, 0,  0, 1, 0, 13, 1, 6}, // R6 differs in msb only
        '{0, 0,  0, 16'h0000, 1, 12, 0, 0,  0, 1, 3},
        '{0, 0,  0, 16'h0000, 0,  0, 1, 1, 12, 1, 4}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        disp_valid = 0; disp_is_store = 0; disp_tag = 0; disp_addr = 0;
        ret_valid = 0; ret_tag = 0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int next_exp;
        rst = 1;
        idle_inputs();
        repeat (3) @(negedge clk);
        #1;
        chk(!cache_valid, "R1", "cache_valid in reset", cache_valid, 0);
        chk(disp_ready, "R1", "disp_ready in reset", disp_ready, 1);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        chk(!cache_valid, "R1", "cache_valid after reset", cache_valid, 0);
        chk(disp_ready, "R1", "disp_ready after reset", disp_ready, 1);

        for (int i = 0; i < 26; i++) begin
            @(negedge clk);
            disp_valid = TBL[i].dv; disp_is_store = TBL[i].st;
            disp_tag = TBL[i].tag;  disp_addr = TBL[i].addr;
            ret_valid = TBL[i].rv;  ret_tag = TBL[i].rtag;
            #1;
            chk(cache_valid == TBL[i].ev, $sformatf("R%0d row %0d", TBL[i].req, i),
                "cache_valid", cache_valid, TBL[i].ev);
            if (TBL[i].ev) begin
                chk(cache_we == TBL[i].ewe, $sformatf("R%0d row %0d", TBL[i].req, i),
                    "cache_we", cache_we, TBL[i].ewe);
                chk(cache_tag == TBL[i].etag, $sformatf("R%0d row %0d", TBL[i].req, i),
                    "cache_tag", cache_tag, TBL[i].etag);
            end
            chk(disp_ready == TBL[i].erdy, $sformatf("R%0d row %0d", TBL[i].req, i),
                "disp_ready", disp_ready, TBL[i].erdy);
        end
        @(negedge clk);
        idle_inputs();

        // R9: two stores fill the buffer, four more fill the queue
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            #1;
            chk(disp_ready, "R9", "disp_ready while filling", disp_ready, 1);
            disp_valid = 1; disp_is_store = 1; disp_tag = 4'(k);
            disp_addr = 16'h0100 + 16'(k);
        end
        @(negedge clk);
        idle_inputs();
        #1;
        chk(!disp_ready, "R9", "disp_ready when queue full", disp_ready, 0);

        // R4: drain in dispatch order, retiring one tag at a time
        next_exp = 1;
        for (int c = 0; c < 60 && next_exp <= 6; c++) begin
            @(negedge clk);
            ret_valid = 1; ret_tag = 4'(next_exp);
            #1;
            if (cache_valid) begin
                chk(cache_we && cache_tag == 4'(next_exp), "R4", "drain order",
                    cache_tag, next_exp);
                next_exp++;
            end
        end
        chk(next_exp == 7, "R4", "stores drained", next_exp, 7);
        @(negedge clk);
        idle_inputs();
        #1;
        chk(disp_ready, "R9", "disp_ready after drain", disp_ready, 1);

        // R1: a buffered store is discarded by reset
        disp_valid = 1; disp_is_store = 1; disp_tag = 4'd5; disp_addr = 16'h0200;
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        rst = 0;
        ret_valid = 1; ret_tag = 4'd5;
        @(negedge clk);
        idle_inputs();
        #1;
        chk(!cache_valid, "R1", "no store after reset", cache_valid, 0);
        @(negedge clk);
        #1;
        chk(!cache_valid, "R1", "still no store after reset", cache_valid, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule